// File: doc/BRIEF.md
# Camera Pixel Capture Interface

This block receives the parallel pixel stream of a CMOS image sensor. Every flop runs on the pixel clock that the sensor supplies. The frame sync (`vsync`) and line-valid (`href`) strobes mark out the active pixels. On each accepted pixel the luma and chroma channel buses are merged into one registered word, with a one-cycle valid strobe.

A mode input selects YUV or raw RGB handling, and the block latches it when a frame starts. In raw RGB mode the first line of every frame carries no usable data, so the block drops it. The block counts the pixels it accepts in each frame. When the next frame sync arrives it presents that total with a one-cycle frame-done pulse. A downstream clock-crossing FIFO would consume the packed words and the frame totals.

Top module: `cam_pixel_capture`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `pix_valid` and `frame_done` are 0 and `frame_count` is 0.
- R2: A pixel is accepted at a `pclk` rising edge when a frame is open, `href` is 1 and `vsync` is 0. After that edge `pix_valid` is 1 for exactly that cycle, and `pix_data` equals `{y_in, c_in}`, with luma in the upper `Y_W` bits.
- R3: No pixel is accepted at an edge where `href` is 0 or `vsync` is 1.
- R4: No pixel is accepted before the first rising edge of `vsync` after reset.
- R5: In raw mode (`raw_mode` = 1 at frame start), no pixels are accepted from the frame start until the first falling edge of `href` after it. Later lines are accepted.
- R6: In YUV mode (`raw_mode` = 0 at frame start), the first line of a frame is accepted.
- R7: `raw_mode` is sampled only at the edge where `vsync` rises. Changes to it within a frame have no effect on that frame.
- R8: A rising edge of `vsync` that closes an open frame sets `frame_done` to 1 for one cycle. At the same time `frame_count` takes the number of pixels accepted in that frame. `frame_count` then holds until the next such pulse.
- R9: The pixel counter restarts at every `vsync` rising edge, so each frame's total counts only its own pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Sensor pixel clock |
| rst_n | input | 1 | Active-low reset, synchronous to `pclk` |
| vsync | input | 1 | Frame sync; a rising edge starts a frame |
| href | input | 1 | Line valid; high during active pixels |
| y_in | input | Y_W | Luma channel bus |
| c_in | input | C_W | Chroma channel bus |
| raw_mode | input | 1 | 1 = raw RGB (drop first line), 0 = YUV |
| pix_data | output | Y_W+C_W | Packed pixel word |
| pix_valid | output | 1 | One-cycle strobe per packed word |
| frame_done | output | 1 | One-cycle pulse when a frame closes |
| frame_count | output | CNT_W | Pixels accepted in the last closed frame |

## Verification
The bench targets the first raw line and a mode flip in mid-frame. A design that sampled the mode continuously, or that dropped the wrong line, would report a frame total off by one line. It also drives `href` while `vsync` is high and before the first frame sync. A design that ignored the sync would emit stray words and inflate the count. Back-to-back frames of random length check that the counter restarts and that the total is taken before the restart. A design that cleared the counter first would report zero, and one that never cleared it would report running totals.

// File: rtl/cam_pixel_capture.sv
module cam_pixel_capture #(
  parameter int Y_W   = 8,
  parameter int C_W   = 8,
  parameter int CNT_W = 20
) (
  input  logic                 pclk,
  input  logic                 rst_n,
  input  logic                 vsync,
  input  logic                 href,
  input  logic [Y_W-1:0]       y_in,
  input  logic [C_W-1:0]       c_in,
  input  logic                 raw_mode,
  output logic [Y_W+C_W-1:0]   pix_data,
  output logic                 pix_valid,
  output logic                 frame_done,
  output logic [CNT_W-1:0]     frame_count
);
  localparam int PW = Y_W + C_W;

  logic             vs_d, hr_d, in_frame, mode_lat, skip_pend;
  logic [CNT_W-1:0] cnt;

  wire vs_rise  = vsync & ~vs_d;
  wire line_end = hr_d & ~href;
  wire take     = in_frame & href & ~vsync & ~(mode_lat & skip_pend);

  always_ff @(posedge pclk) begin
    if (!rst_n) begin
      vs_d        <= 1'b0;
      hr_d        <= 1'b0;
      in_frame    <= 1'b0;
      mode_lat    <= 1'b0;
      skip_pend   <= 1'b0;
      cnt         <= '0;
      pix_data    <= '0;
      pix_valid   <= 1'b0;
      frame_done  <= 1'b0;
      frame_count <= '0;
    end else begin
      vs_d       <= vsync;
      hr_d       <= href;
      pix_valid  <= take;
      frame_done <= vs_rise & in_frame;
      if (take) begin
        pix_data <= PW'({y_in, c_in});
        cnt      <= cnt + CNT_W'(1);
      end
      if (vs_rise) begin
        in_frame  <= 1'b1;
        mode_lat  <= raw_mode;
        skip_pend <= 1'b1;
        cnt       <= '0;
        if (in_frame) frame_count <= cnt;
      end else if (line_end) begin
        skip_pend <= 1'b0;
      end
    end
  end

  AST_VALID_GATED: assert property (@(posedge pclk) disable iff (!rst_n)
    pix_valid |-> ($past(href) && !$past(vsync)));  // R3
  AST_NO_EARLY_PIXEL: assert property (@(posedge pclk) disable iff (!rst_n)
    !in_frame |=> !pix_valid);  // R4
  AST_MODE_HELD: assert property (@(posedge pclk) disable iff (!rst_n)
    !(vsync && !vs_d) |=> $stable(mode_lat));  // R7
  AST_DONE_PULSE: assert property (@(posedge pclk) disable iff (!rst_n)
    frame_done |=> !frame_done);  // R8
  AST_DONE_NO_PIXEL: assert property (@(posedge pclk) disable iff (!rst_n)
    frame_done |-> ($past(vsync) && !pix_valid));  // R8
  AST_COUNT_HELD: assert property (@(posedge pclk) disable iff (!rst_n)
    !frame_done |-> $stable(frame_count));  // R8
endmodule

// File: tb/sim_cam_pixel_capture.sv
module sim_cam_pixel_capture;
  localparam int Y_W = 8, C_W = 8, CNT_W = 20;
  logic pclk = 1'b0, rst_n = 1'b0, vsync = 1'b0, href = 1'b0, raw_mode = 1'b0;
  logic [Y_W-1:0] y_in = '0;
  logic [C_W-1:0] c_in = '0;
  logic [Y_W+C_W-1:0] pix_data;
  logic pix_valid, frame_done;
  logic [CNT_W-1:0] frame_count;

  int checks = 0, fails = 0;
  bit m_in = 0, m_mode = 0, m_pend = 0, m_vsd = 0, m_hrd = 0;
  int m_cnt = 0, m_fc = 0, last_total = -1, seed;

  always #4 pclk = ~pclk;

  cam_pixel_capture #(.Y_W(Y_W), .C_W(C_W), .CNT_W(CNT_W)) u0 (
    .pclk(pclk), .rst_n(rst_n), .vsync(vsync), .href(href), .y_in(y_in), .c_in(c_in),
    .raw_mode(raw_mode), .pix_data(pix_data), .pix_valid(pix_valid),
    .frame_done(frame_done), .frame_count(frame_count));

  function automatic bit exp_take(bit vs, bit hr);
    return m_in && hr && !vs && !(m_mode && m_pend);
  endfunction

  function automatic string why(bit vs, bit hr);
    if (!m_in) return "R4";
    if (vs || !hr) return "R3";
    if (m_mode && m_pend) return "R5";
    return m_mode ? "R2" : "R6";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit vs, bit hr, bit md);
    bit ev, ed;
    logic [Y_W+C_W-1:0] ed_data;
    string rq;
    vsync = vs; href = hr; raw_mode = md;
    y_in = Y_W'($urandom); c_in = C_W'($urandom);
    ev = exp_take(vs, hr);
    rq = why(vs, hr);
    ed_data = {y_in, c_in};
    ed = vs && !m_vsd && m_in;
    if (ev) m_cnt++;
    if (vs && !m_vsd) begin
      if (m_in) m_fc = m_cnt - (ev ? 1 : 0);
      m_in = 1; m_mode = md; m_pend = 1; m_cnt = 0;
    end else if (m_hrd && !hr) m_pend = 0;
    m_vsd = vs; m_hrd = hr;
    @(posedge pclk); #1;
    check(pix_valid == ev, rq, "pix_valid", pix_valid, ev);
    if (ev) check(pix_data == ed_data, "R2", "pix_data", pix_data, ed_data);
    check(frame_done == ed, "R8", "frame_done", frame_done, ed);
    check(frame_count == CNT_W'(m_fc), "R9", "frame_count", frame_count, m_fc);
    if (frame_done) last_total = int'(frame_count);
  endtask

  task automatic line(int n, bit md);
    for (int i = 0; i < n; i++) cyc(0, 1, md);
    cyc(0, 0, md);
    cyc(0, 0, md);
  endtask

  task automatic vpulse(int n, bit md);
    for (int i = 0; i < n; i++) cyc(1, 0, md);
    cyc(0, 0, md);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    seed = $urandom(32'd2024);
    repeat (3) @(posedge pclk);
    #1;
    check(!pix_valid && !frame_done && frame_count == 0, "R1", "reset outputs",
          {pix_valid, frame_done}, 0);
    rst_n = 1'b1;
    cyc(0, 0, 0);
    check(!pix_valid && frame_count == 0, "R1", "after reset", pix_valid, 0);
    line(5, 0);                        // R4: pixels before any frame sync
    vpulse(2, 1);                      // raw frame
    line(4, 1); line(4, 1);
    vpulse(1, 0);                      // closes raw frame, opens YUV frame
    check(last_total == 4, "R5", "raw frame total", last_total, 4);
    line(4, 0);
    line(4, 1);                        // R7: mode flip mid-frame
    vpulse(1, 0);
    check(last_total == 8, "R6", "yuv frame total", last_total, 8);
    cyc(1, 1, 0); cyc(1, 1, 0); cyc(0, 0, 0);   // R3: href under vsync ignored
    line(3, 0);
    vpulse(1, 1);
    check(last_total == 3, "R3", "href during vsync", last_total, 3);
    cyc(0, 1, 1); cyc(0, 1, 1); cyc(0, 0, 1);   // R5: dropped first raw line
    line(2, 0);
    vpulse(1, 0);
    check(last_total == 2, "R5", "first raw line dropped", last_total, 2);
    for (int f = 0; f < 40; f++) begin
      bit md = 1'($urandom);
      vpulse(1 + ($urandom % 3), md);
      for (int l = 0; l < 1 + int'($urandom % 5); l++) begin
        for (int p = 0; p < 1 + int'($urandom % 12); p++)
          cyc(0, 1, ($urandom % 8 == 0) ? ~md : md);
        for (int g = 0; g < 1 + int'($urandom % 3); g++) cyc(0, 0, md);
      end
    end
    vpulse(1, 0);
    check(last_total == m_fc, "R9", "final frame total", last_total, m_fc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule